// File: doc/BRIEF.md
# Conditional-Inversion Line Word Encoder

This block turns a stream of 16-bit payloads into 20-bit line words for a serializer that runs with its own block coding and elastic buffering switched off. Each word carries a 4-bit type field ahead of the payload field. The type field marks the word as data, control or idle. Inside the type field, the second and third bits sent always differ, so the receiver sees a level change at a known point in every word and can keep its clock recovery locked.

A new word is presented on every word clock, at 40 MHz for an 800 Mb/s line. When no payload is offered, the block fills the slot with an idle word. The encoder keeps a signed running disparity across all words it sends. It complements a whole word, type field included, when sending that word unchanged would push the running total further from zero. The complemented type codes tell the far end to undo the inversion.

The path has a fixed depth of two registers and contains no FIFO. The delay from input to line is therefore the same for every word type and for every traffic pattern. Trigger logic downstream can rely on that constant delay.

Top module: `invLinkEncoder`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, lineWord holds the plain idle word 0xB00FF.
- R2: A word offered at clock edge k appears on lineWord just after edge k+1. This two-cycle latency is the same for data, control and idle words.
- R3: lineWord[19:16] is the type field, with bit 19 sent first. lineWord[15:0] is the payload field. On an inverted word both fields are the bitwise complement of their plain values.
- R4: The plain type codes are data 1100, control 1101 and idle 1011. The inverted type codes are 0011, 0010 and 0100.
- R5: When payloadValid is 0, the block emits an idle word whose plain payload field is 0x00FF. The payload input has no effect on that word.
- R6: On every word, lineWord[18] differs from lineWord[17].
- R7: A word's disparity is twice its count of ones minus 20. The block inverts a word only when the plain word's disparity and the running disparity are both strictly positive or both strictly negative. It then adds the disparity of the word actually sent to the running total, which starts at 0 after reset.
- R8: The summed disparity of all words sent since reset stays within -20 to +20.
- R9: wordKind encodes 0 as data and 1 as control. With payloadValid at 1, the values 2 and 3 produce an idle word, and the payload input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| payloadValid | input | 1 | A payload is offered this cycle |
| wordKind | input | 2 | Requested word type (0 data, 1 control, 2/3 idle) |
| payload | input | 16 | Payload for the current word |
| lineWord | output | 20 | Encoded line word; bit 19 is sent first |

## Verification
The input patterns include:
- Idle-only streams with noisy payload inputs. These show whether the fill word really ignores the payload and whether its polarity alternates.
- Runs of all-ones and all-zeros data. These drive the disparity hard to each side, which separates a correct inversion decision from a wrong sign test or a wrong accumulation.
- Mixed and checkerboard payloads. Their disparity is zero, so they must never be inverted.
- Control words and the reserved type values. These separate the type-field decode paths.
- A single data word inserted between idles. This pins the output cycle and exposes any extra or missing pipeline stage.

// File: rtl/invLinkPkg.sv
package invLinkPkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CTRL = 2'd1,
    KIND_IDLE = 2'd2
  } wordKind_e;

  // plain type codes; bit 3 leaves first, bits 2 and 1 always differ
  localparam logic [CODE_W-1:0] CODE_DATA = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_CTRL = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_IDLE = 4'b1011;

  typedef struct packed {
    logic [CODE_W-1:0] fieldCode;
    logic              invertWord;
  } encStrobe_t;

endpackage

// File: rtl/invLinkCtrl.sv
module invLinkCtrl
  import invLinkPkg::*;
#(
  parameter int DISP_W = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     payloadValid,
  input  logic [1:0]               wordKindIn,
  input  logic signed [DISP_W-1:0] wordDisp,
  output logic                     idleSel,
  output encStrobe_t               strobe
);

  wordKind_e resolvedKind;
  wordKind_e kindQ;
  logic signed [DISP_W-1:0] runDisp;
  logic signed [DISP_W-1:0] runDispNext;
  logic invertNow;

  // stage 0: resolve the requested type
  always_comb begin
    if (!payloadValid)            resolvedKind = KIND_IDLE;
    else if (wordKindIn == 2'd0)  resolvedKind = KIND_DATA;
    else if (wordKindIn == 2'd1)  resolvedKind = KIND_CTRL;
    else                          resolvedKind = KIND_IDLE;
  end

  assign idleSel = (resolvedKind == KIND_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kindQ <= KIND_IDLE;
    else       kindQ <= resolvedKind;
  end

  // stage 1: type code and balance decision
  always_comb begin
    case (kindQ)
      KIND_DATA: strobe.fieldCode = CODE_DATA;
      KIND_CTRL: strobe.fieldCode = CODE_CTRL;
      default:   strobe.fieldCode = CODE_IDLE;
    endcase
  end

  assign invertNow = ((runDisp > 0) && (wordDisp > 0)) ||
                     ((runDisp < 0) && (wordDisp < 0));
  assign strobe.invertWord = invertNow;
  assign runDispNext = invertNow ? (runDisp - wordDisp) : (runDisp + wordDisp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runDisp <= '0;
    else       runDisp <= runDispNext;
  end

endmodule

// File: rtl/invLinkDatapath.sv
module invLinkDatapath
  import invLinkPkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int DISP_W    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PAYLOAD_W-1:0]        payloadIn,
  input  logic                        idleSel,
  input  encStrobe_t                  strobe,
  output logic signed [DISP_W-1:0]    wordDisp,
  output logic [CODE_W+PAYLOAD_W-1:0] lineWord
);

  localparam int WORD_W = CODE_W + PAYLOAD_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [PAYLOAD_W-1:0] IDLE_PAYLOAD =
    PAYLOAD_W'((64'd1 << (PAYLOAD_W / 2)) - 64'd1);

  logic [PAYLOAD_W-1:0] payloadQ;
  logic [WORD_W-1:0]    rawWord;
  logic [CNT_W-1:0]     onesCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        payloadQ <= IDLE_PAYLOAD;
    else if (idleSel) payloadQ <= IDLE_PAYLOAD;
    else              payloadQ <= payloadIn;
  end

  assign rawWord = {strobe.fieldCode, payloadQ};

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < WORD_W; i++) onesCnt = onesCnt + CNT_W'(rawWord[i]);
  end

  assign wordDisp = $signed(DISP_W'(onesCnt) <<< 1) - $signed(DISP_W'(WORD_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lineWord <= {CODE_IDLE, IDLE_PAYLOAD};
    else if (strobe.invertWord) lineWord <= ~rawWord;
    else                        lineWord <= rawWord;
  end

endmodule

// File: rtl/invLinkEncoder.sv
module invLinkEncoder
  import invLinkPkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        payloadValid,
  input  logic [1:0]                  wordKind,
  input  logic [PAYLOAD_W-1:0]        payload,
  output logic [CODE_W+PAYLOAD_W-1:0] lineWord
);

  localparam int WORD_W = CODE_W + PAYLOAD_W;
  localparam int DISP_W = $clog2(WORD_W + 1) + 2;

  encStrobe_t strobe;
  logic idleSel;
  logic signed [DISP_W-1:0] wordDisp;

  invLinkCtrl #(.DISP_W(DISP_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .payloadValid (payloadValid),
    .wordKindIn   (wordKind),
    .wordDisp     (wordDisp),
    .idleSel      (idleSel),
    .strobe       (strobe)
  );

  invLinkDatapath #(.PAYLOAD_W(PAYLOAD_W), .DISP_W(DISP_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .payloadIn (payload),
    .idleSel   (idleSel),
    .strobe    (strobe),
    .wordDisp  (wordDisp),
    .lineWord  (lineWord)
  );

endmodule

// File: rtl/invLinkChecker.sv
module invLinkChecker
  import invLinkPkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        payloadValid,
  input logic [1:0]                  wordKind,
  input logic [PAYLOAD_W-1:0]        payload,
  input logic [CODE_W+PAYLOAD_W-1:0] lineWord
);

  localparam int WORD_W = CODE_W + PAYLOAD_W;
  localparam logic [PAYLOAD_W-1:0] IDLE_PAY =
    PAYLOAD_W'((64'd1 << (PAYLOAD_W / 2)) - 64'd1);

  logic [1:0] sinceRst;
  int accDisp;
  logic [CODE_W-1:0] codeF;
  logic [PAYLOAD_W-1:0] payF;

  assign codeF = lineWord[WORD_W-1 -: CODE_W];
  assign payF  = lineWord[PAYLOAD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      accDisp  <= 0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (sinceRst != 2'd0) accDisp <= accDisp + 2 * $countones(lineWord) - WORD_W;
    end
  end

  a_r1_reset_word: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (lineWord == {CODE_IDLE, IDLE_PAY}));

  a_r6_mid_transition: assert property (@(posedge clk) disable iff (!rstN)
    lineWord[WORD_W-2] != lineWord[WORD_W-3]);

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    (codeF == CODE_DATA) || (codeF == CODE_CTRL) || (codeF == CODE_IDLE) ||
    (codeF == ~CODE_DATA) || (codeF == ~CODE_CTRL) || (codeF == ~CODE_IDLE));

  a_r2_data_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(payloadValid, 2) && $past(wordKind, 2) == 2'd0) |->
    ((codeF == CODE_DATA && payF == $past(payload, 2)) ||
     (codeF == ~CODE_DATA && payF == ~$past(payload, 2))));

  a_r5_idle_fill: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(payloadValid, 2)) |->
    ((codeF == CODE_IDLE && payF == IDLE_PAY) ||
     (codeF == ~CODE_IDLE && payF == ~IDLE_PAY)));

  a_r8_balance_bound: assert property (@(posedge clk) disable iff (!rstN)
    (accDisp <= WORD_W) && (accDisp >= -WORD_W));

endmodule

bind invLinkEncoder invLinkChecker #(.PAYLOAD_W(PAYLOAD_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .payloadValid (payloadValid),
  .wordKind     (wordKind),
  .payload      (payload),
  .lineWord     (lineWord)
);

// File: tb/sim_invLinkEncoder.sv
module sim_invLinkEncoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic payloadValid = 1'b0;
  logic [1:0] wordKind = 2'd0;
  logic [15:0] payload = 16'h0;
  logic [19:0] lineWord;

  int nChecks = 0;
  int nBad = 0;
  int modelRd = 0;
  int obsAcc = 0;
  logic [19:0] exp1, exp2;
  string tag1, tag2;

  always #10 clk = ~clk;

  invLinkEncoder u0 (
    .clk(clk), .rstN(rstN), .payloadValid(payloadValid),
    .wordKind(wordKind), .payload(payload), .lineWord(lineWord)
  );

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected word from the requirement rules (R4, R5, R7, R9)
  function automatic logic [19:0] model(input logic v, input logic [1:0] k, input logic [15:0] p);
    logic [19:0] w;
    int d;
    bit inv;
    if (v && k == 2'd0)      w = {4'b1100, p};
    else if (v && k == 2'd1) w = {4'b1101, p};
    else                     w = {4'b1011, 16'h00FF};
    d = 2 * $countones(w) - 20;
    inv = (modelRd > 0 && d > 0) || (modelRd < 0 && d < 0);
    if (inv) begin
      w = ~w;
      modelRd = modelRd - d;
    end else begin
      modelRd = modelRd + d;
    end
    return w;
  endfunction

  task automatic step(input logic v, input logic [1:0] k, input logic [15:0] p, input string tag);
    @(negedge clk);
    chk(lineWord == exp2, tag2, lineWord, exp2);
    chk(lineWord[18] != lineWord[17], "R6 mid-field transition", lineWord, exp2);
    obsAcc = obsAcc + 2 * $countones(lineWord) - 20;
    chk(obsAcc <= 20 && obsAcc >= -20, "R8 balance bound", 20'(obsAcc), 20'd20);
    exp2 = exp1;
    tag2 = tag1;
    payloadValid = v;
    wordKind = k;
    payload = p;
    exp1 = model(v, k, p);
    tag1 = tag;
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    chk(lineWord == 20'hB00FF, "R1 reset word", lineWord, 20'hB00FF);
    rstN = 1'b1;
    modelRd = 0;
    obsAcc = 0;
    exp2 = model(1'b0, 2'd0, 16'h0);
    tag2 = "R1 first word after reset";
    exp1 = model(1'b0, 2'd0, 16'h0);
    tag1 = "R1 second word after reset";
  endtask

  task automatic tIdle;
    for (int i = 0; i < 8; i++) step(1'b0, 2'(i), 16'hA5C3 ^ 16'(i * 7919), "R5 idle fill ignores payload");
  endtask

  task automatic tLatency;
    step(1'b1, 2'd0, 16'h1234, "R2 lone data word");
    step(1'b0, 2'd0, 16'hFFFF, "R2 idle after data");
    step(1'b1, 2'd1, 16'h0F0F, "R2 lone control word");
    step(1'b0, 2'd0, 16'h0, "R2 idle after control");
    step(1'b0, 2'd0, 16'h0, "R2 idle");
  endtask

  task automatic tDataBalance;
    for (int i = 0; i < 6; i++) step(1'b1, 2'd0, 16'hFFFF, "R7 all-ones data");
    for (int i = 0; i < 6; i++) step(1'b1, 2'd0, 16'h0000, "R7 all-zeros data");
    for (int i = 0; i < 4; i++) step(1'b1, 2'd0, 16'hAA55, "R7 zero-disparity data");
    step(1'b1, 2'd0, 16'hFFFF, "R3 field layout");
    step(1'b1, 2'd0, 16'h00F0, "R3 field layout");
  endtask

  task automatic tControl;
    step(1'b1, 2'd1, 16'hFFFF, "R4 control code");
    step(1'b1, 2'd1, 16'hFFFF, "R4 control code inverted");
    step(1'b1, 2'd1, 16'h0001, "R4 control code");
    step(1'b1, 2'd0, 16'h8000, "R4 data code");
  endtask

  task automatic tReserved;
    step(1'b1, 2'd2, 16'hDEAD, "R9 kind 2 is idle");
    step(1'b1, 2'd3, 16'hBEEF, "R9 kind 3 is idle");
    step(1'b1, 2'd2, 16'h0000, "R9 kind 2 is idle");
    step(1'b1, 2'd3, 16'hFFFF, "R9 kind 3 is idle");
  endtask

  task automatic tMixed;
    for (int i = 0; i < 40; i++)
      step(i % 5 != 0, 2'(i % 3), 16'(i * 40503 + 17), "R7 mixed traffic");
    step(1'b0, 2'd0, 16'h0, "R2 drain");
    step(1'b0, 2'd0, 16'h0, "R2 drain");
  endtask

  initial begin
    tReset;
    tIdle;
    tLatency;
    tDataBalance;
    tControl;
    tReserved;
    tMixed;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule